// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

This block takes a stereo audio stream on a three-wire serial input (bit clock, channel-select frame sync and data) and sends it out as a single biphase-mark line signal made of 32-slot subframes. The serial input can be framed three ways: words start at the frame-sync change, words start one bit clock later, or words end at the frame-sync change. Words can be 16, 18, 20 or 24 bits long. The block turns each left/right pair back into two 24-bit samples. It then places them in the left and right subframes of one output frame, together with a preamble, a validity flag, a user bit, one channel-status bit and an even parity bit. Frames are grouped into blocks of 192.

Everything runs on one system clock. The serial bit clock, frame sync and data are sampled through a selectable number of synchroniser stages. The line encoder advances one half bit-cell on each cycle in which the `cell_tick` enable is high, so `cell_tick` must pulse at twice the output bit rate. The 192-bit channel-status word is fixed by a parameter. Output frame timing runs freely from the first `cell_tick` after reset. When no new pair has arrived by the start of a frame, the last pair is sent again and marked as not valid.

Top module: `spdif_tx`

## Requirements
- R1: During reset and until the first `cell_tick`, `line_out` is 0. The first frame after reset has no sample to send, so it carries zero audio with the validity bit set to 1 in both subframes.
- R2: `line_out` changes only in the cycle after a `cell_tick`. In slots 4 to 31 every bit cell starts with a toggle of the line, and a bit of value 1 adds a second toggle between its two halves.
- R3: Each subframe starts with an 8-half-cell preamble. Assuming the line was 0 before it, the patterns are 11101000 for the left subframe of frame 0 of each 192-frame block, 11100010 for all other left subframes, and 11100100 for every right subframe. When the line was 1 before the preamble, the pattern is inverted.
- R4: Slots 4 to 27 carry the 24-bit sample LSB first: slot 4 is bit 0 and slot 27 is bit 23. Slot 28 is the validity bit (1 = not valid), slot 29 is the user bit (always 0), slot 30 is the channel-status bit and slot 31 is the parity bit.
- R5: Slots 4 to 31 of every subframe contain an even number of ones. As a result, the line ends each subframe at the level it had before the preamble.
- R6: Both subframes of frame f (0 to 191) carry bit f of the `CSTAT` parameter in slot 30.
- R7: With `fmt` = 0, the frame sync is high for the left word and low for the right word, and the MSB is the data bit sampled on the first bit-clock rise after the frame sync changes. Bits after the word's LSB are ignored.
- R8: With `fmt` = 1, the frame sync is low for the left word and high for the right word, and the MSB is sampled on the second bit-clock rise after the frame sync changes.
- R9: With `fmt` = 2, the frame sync is high for the left word, and the LSB is sampled on the last bit-clock rise before the frame sync changes. Bits before the word's MSB are ignored.
- R10: `word_len` codes 0, 1, 2 and 3 select 16, 18, 20 and 24-bit words. A shorter word is placed at the top of the 24-bit sample, and the unused low bits are 0.
- R11: At each frame start, a pair received since the last frame start is sent with validity 0. If there is none, the previous pair is sent again with validity 1. Pairs are sent in the order they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Serial framing: 0 = starts at frame-sync change, 1 = one-bit delay, 2 = ends at change |
| word_len | input | 2 | Word length code: 16/18/20/24 bits |
| bclk | input | 1 | Serial bit clock (data taken on its rising edge) |
| fsync | input | 1 | Channel-select frame sync |
| sdata | input | 1 | Serial data, MSB first |
| cell_tick | input | 1 | Half-cell advance enable at twice the output bit rate |
| line_out | output | 1 | Biphase-mark line signal |

## Verification
The hardest case to reach from the ports is a frame start with no new pair waiting. The input and output rates are set exactly equal, so this would never happen on its own. The stimulus creates it by stopping the bit clock for three frame periods in the middle of a long run. This forces repeated frames with the validity bit set, and the first pair after the pause must then go out unchanged. The same long run crosses a 192-frame boundary, so the block-start preamble and every channel-status bit are seen. In short runs of the other framings, all unused slot bits are driven to 1, which exposes any bits that should have been ignored but were captured.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

   localparam int unsigned SAMPLE_W = 24;
   localparam int unsigned SLOT_HALVES = 64;

   typedef enum logic [1:0] {
      FMT_LEFT  = 2'd0,
      FMT_DELAY = 2'd1,
      FMT_RIGHT = 2'd2
   } ser_fmt_e;

   // preamble half-cell patterns, MSB sent first, for a line previously at 0
   localparam logic [7:0] PRE_BLOCK = 8'b11101000;
   localparam logic [7:0] PRE_LEFT  = 8'b11100010;
   localparam logic [7:0] PRE_RIGHT = 8'b11100100;

   function automatic logic [4:0] word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 5'd16;
         2'd1:    return 5'd18;
         2'd2:    return 5'd20;
         default: return 5'd24;
      endcase
   endfunction

endpackage

// File: rtl/spdif_tx_deser.sv
module spdif_tx_deser
   import spdif_tx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          fmt,
   input  logic [1:0]          word_len,
   input  logic                bclk,
   input  logic                fsync,
   input  logic                sdata,
   output logic                pair_stb,
   output logic [SAMPLE_W-1:0] pair_l,
   output logic [SAMPLE_W-1:0] pair_r
);
   localparam int unsigned CW = 6;
   localparam logic [CW-1:0] CMAX = '1;

   logic bclk_s, fs_s, sd_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign {bclk_s, fs_s, sd_s} = {bclk, fsync, sdata};
      end else begin : g_sync
         logic [2:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= {bclk, fsync, sdata};
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign {bclk_s, fs_s, sd_s} = stg[SYNC_STAGES-1];
      end
   endgenerate

   logic                bclk_q, fs_prev, have_left;
   logic [CW-1:0]       cnt, idx, tgt;
   logic [SAMPLE_W-1:0] sr, sr_nx, left_q, word;
   logic                rise, chg, is_dly, is_rj, left_lvl, cap, cap_left;
   logic [4:0]          nb;

   always_comb begin
      nb       = word_bits(word_len);
      is_dly   = (fmt == FMT_DELAY);
      is_rj    = (fmt == FMT_RIGHT);
      left_lvl = ~is_dly;
      rise     = bclk_s & ~bclk_q;
      chg      = fs_s ^ fs_prev;
      idx      = chg ? '0 : cnt;
      sr_nx    = {sr[SAMPLE_W-2:0], sd_s};
      tgt      = CW'(nb) - CW'(!is_dly);
      if (is_rj) begin
         cap      = rise & chg;
         cap_left = (fs_prev == left_lvl);
         word     = sr << (SAMPLE_W - 32'(nb));
      end else begin
         cap      = rise & (idx == tgt);
         cap_left = (fs_s == left_lvl);
         word     = sr_nx << (SAMPLE_W - 32'(nb));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q    <= 1'b0;
         fs_prev   <= 1'b0;
         cnt       <= CMAX;
         sr        <= '0;
         left_q    <= '0;
         have_left <= 1'b0;
         pair_stb  <= 1'b0;
         pair_l    <= '0;
         pair_r    <= '0;
      end else begin
         bclk_q   <= bclk_s;
         pair_stb <= 1'b0;
         if (rise) begin
            fs_prev <= fs_s;
            sr      <= sr_nx;
            cnt     <= (idx == CMAX) ? CMAX : idx + 1'b1;
            if (cap) begin
               if (cap_left) begin
                  left_q    <= word;
                  have_left <= 1'b1;
               end else if (have_left) begin
                  pair_l    <= left_q;
                  pair_r    <= word;
                  pair_stb  <= 1'b1;
                  have_left <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/spdif_tx_framer.sv
module spdif_tx_framer
   import spdif_tx_pkg::*;
#(
   parameter int unsigned             BLOCK_FRAMES = 192,
   parameter logic [BLOCK_FRAMES-1:0] CSTAT        = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cell_tick,
   input  logic                pair_stb,
   input  logic [SAMPLE_W-1:0] pair_l,
   input  logic [SAMPLE_W-1:0] pair_r,
   output logic                line_out
);
   localparam int unsigned FW = $clog2(BLOCK_FRAMES);
   localparam logic [FW-1:0] FLAST = FW'(BLOCK_FRAMES - 1);

   logic [5:0]          h;
   logic                ch, pol_q, pend, vflag;
   logic [FW-1:0]       frm;
   logic [SAMPLE_W-1:0] cur_l, cur_r, pend_l, pend_r, word;
   logic [31:0]         slots;
   logic [7:0]          pre;
   logic                cbit, par, pol, line_nx;

   always_comb begin
      word  = ch ? cur_r : cur_l;
      cbit  = CSTAT[frm];
      par   = ^word ^ vflag ^ cbit;
      slots = {par, cbit, 1'b0, vflag, word, 4'b0000};
      pre   = ch ? PRE_RIGHT : ((frm == '0) ? PRE_BLOCK : PRE_LEFT);
      pol   = (h == '0) ? line_out : pol_q;
      if (h[5:3] == 3'd0)
         line_nx = pre[~h[2:0]] ^ pol;
      else if (!h[0])
         line_nx = ~line_out;
      else
         line_nx = line_out ^ slots[h[5:1]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h        <= '0;
         ch       <= 1'b0;
         frm      <= '0;
         pol_q    <= 1'b0;
         line_out <= 1'b0;
         cur_l    <= '0;
         cur_r    <= '0;
         vflag    <= 1'b1;
         pend     <= 1'b0;
         pend_l   <= '0;
         pend_r   <= '0;
      end else begin
         if (cell_tick) begin
            line_out <= line_nx;
            h        <= h + 1'b1;
            if (h == '0) pol_q <= line_out;
            if (h == '0 && !ch) begin
               if (pend) begin
                  cur_l <= pend_l;
                  cur_r <= pend_r;
                  vflag <= 1'b0;
               end else begin
                  vflag <= 1'b1;
               end
               pend <= 1'b0;
            end
            if (h == 6'd63) begin
               ch <= ~ch;
               if (ch) frm <= (frm == FLAST) ? '0 : frm + 1'b1;
            end
         end
         if (pair_stb) begin
            pend   <= 1'b1;
            pend_l <= pair_l;
            pend_r <= pair_r;
         end
      end
   end

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
   import spdif_tx_pkg::*;
#(
   parameter int unsigned             SYNC_STAGES  = 2,
   parameter int unsigned             BLOCK_FRAMES = 192,
   parameter logic [BLOCK_FRAMES-1:0] CSTAT        = BLOCK_FRAMES'(8'b0000_0110)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] fmt,
   input  logic [1:0] word_len,
   input  logic       bclk,
   input  logic       fsync,
   input  logic       sdata,
   input  logic       cell_tick,
   output logic       line_out
);
   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("spdif_tx: SYNC_STAGES must be 0 to 4");
      end
      if (BLOCK_FRAMES < 2) begin : g_bad_block
         $error("spdif_tx: BLOCK_FRAMES must be at least 2");
      end
   endgenerate

   logic                pair_stb;
   logic [SAMPLE_W-1:0] pair_l, pair_r;

   spdif_tx_deser #(.SYNC_STAGES(SYNC_STAGES)) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt      (fmt),
      .word_len (word_len),
      .bclk     (bclk),
      .fsync    (fsync),
      .sdata    (sdata),
      .pair_stb (pair_stb),
      .pair_l   (pair_l),
      .pair_r   (pair_r)
   );

   spdif_tx_framer #(.BLOCK_FRAMES(BLOCK_FRAMES), .CSTAT(CSTAT)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cell_tick (cell_tick),
      .pair_stb  (pair_stb),
      .pair_l    (pair_l),
      .pair_r    (pair_r),
      .line_out  (line_out)
   );

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic cell_tick,
   input logic line_out
);
   logic [5:0] hc;
   logic       lvl0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc   <= '0;
         lvl0 <= 1'b0;
      end else if (cell_tick) begin
         hc <= hc + 1'b1;
         if (hc == 6'd0) lvl0 <= line_out;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) assert_reset_quiet_R1: assert (line_out == 1'b0);
   end

   assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_tick |=> $stable(line_out));

   assert_cell_edge_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_tick && !hc[0] && hc >= 6'd8) |=> (line_out != $past(line_out)));

   assert_preamble_lead_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_tick && hc == 6'd0) |=> (line_out != $past(line_out)));

   assert_subframe_level_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_tick && hc == 6'd63) |=> (line_out == lvl0));

endmodule

bind spdif_tx spdif_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cell_tick (cell_tick),
   .line_out  (line_out)
);

// File: tb/tb_spdif_tx.sv
module tb_spdif_tx;
   localparam logic [191:0] CS_T = {64'hA5A5_0000_1234_8001,
                                    64'h0F0F_F0F0_0000_0001,
                                    64'hDEAD_BEEF_0000_0006};

   logic clk = 1'b0, rst_n = 1'b0;
   logic bclk = 1'b0, fsync = 1'b0, sdata = 1'b0, cell_tick = 1'b0;
   logic [1:0] fmt = 2'd0, word_len = 2'd3;
   logic line_out;
   logic run_tick = 1'b0;

   always #10 clk = ~clk;

   spdif_tx #(.SYNC_STAGES(2), .BLOCK_FRAMES(192), .CSTAT(CS_T)) dut (
      .clk(clk), .rst_n(rst_n), .fmt(fmt), .word_len(word_len),
      .bclk(bclk), .fsync(fsync), .sdata(sdata),
      .cell_tick(cell_tick), .line_out(line_out)
   );

   int n_vec = 0, n_bad = 0, n_rep = 0;
   logic [47:0] exp_q[$];
   logic [23:0] prev_l = '0, prev_r = '0;
   string audio_req = "R7";
   logic [31:0] seed = 32'h1234_5678;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) cell_tick <= run_tick ? ~cell_tick : 1'b0;

   // monitor: decode the line, pop expected pairs
   logic [63:0] halves;
   int hpos = 0, frame_no = 0, sub = 0;
   logic lvl_prev = 1'b0;
   logic [23:0] aud [2];
   logic vb [2];

   task automatic decode_sub();
      logic [7:0] pat, expp;
      logic [31:0] bits;
      logic last, ok_bmc;
      logic [47:0] e;
      expp = (sub == 1) ? 8'b11100100 : ((frame_no % 192 == 0) ? 8'b11101000 : 8'b11100010);
      if (lvl_prev) expp = ~expp;
      for (int k = 0; k < 8; k++) pat[7-k] = halves[k];
      check("R3 preamble", 64'(pat), 64'(expp));
      ok_bmc = 1'b1;
      last = halves[7];
      bits = '0;
      for (int s = 4; s < 32; s++) begin
         if (halves[2*s] == last) ok_bmc = 1'b0;
         bits[s] = halves[2*s] ^ halves[2*s+1];
         last = halves[2*s+1];
      end
      check("R2 biphase cell edges", 64'(ok_bmc), 64'd1);
      lvl_prev = halves[63];
      check("R5 even parity", 64'(^bits[31:4]), 64'd0);
      check("R4 user bit", 64'(bits[29]), 64'd0);
      check("R6 channel status", 64'(bits[30]), 64'(CS_T[frame_no % 192]));
      aud[sub] = bits[27:4];
      vb[sub] = bits[28];
      if (sub == 1) begin
         check("R11 validity equal in both subframes", 64'(vb[0]), 64'(vb[1]));
         if (frame_no == 0) check("R1 first frame not valid", 64'(vb[1]), 64'd1);
         if (vb[1] == 1'b0) begin
            if (exp_q.size() == 0) check("R11 fresh frame without sample", 64'd1, 64'd0);
            else begin
               e = exp_q.pop_front();
               check({audio_req, " left sample"}, 64'(aud[0]), 64'(e[47:24]));
               check({audio_req, " right sample"}, 64'(aud[1]), 64'(e[23:0]));
               prev_l = e[47:24];
               prev_r = e[23:0];
            end
         end else begin
            n_rep++;
            check("R11 repeated left", 64'(aud[0]), 64'(prev_l));
            check("R11 repeated right", 64'(aud[1]), 64'(prev_r));
         end
         frame_no++;
      end
      sub ^= 1;
   endtask

   initial forever begin
      @(posedge clk);
      if (!rst_n) begin
         hpos = 0; frame_no = 0; sub = 0; lvl_prev = 1'b0;
      end else if (cell_tick) begin
         @(negedge clk);
         halves[hpos] = line_out;
         hpos++;
         if (hpos == 64) begin
            hpos = 0;
            decode_sub();
         end
      end
   end

   // driver
   task automatic bit_out(input logic fs, input logic d);
      @(negedge clk); fsync = fs; sdata = d; bclk = 1'b0;
      @(negedge clk);
      @(negedge clk); bclk = 1'b1;
      @(negedge clk);
   endtask

   function automatic int nbits(input logic [1:0] code);
      return (code == 2'd0) ? 16 : (code == 2'd1) ? 18 : (code == 2'd2) ? 20 : 24;
   endfunction

   function automatic logic [31:0] slot_pat(input logic [23:0] x, input int nb, input logic [1:0] f);
      logic [31:0] p = '1;
      for (int i = 0; i < nb; i++) begin
         if (f == 2'd0)      p[31-i] = x[nb-1-i];
         else if (f == 2'd1) p[30-i] = x[nb-1-i];
         else                p[i]    = x[i];
      end
      return p;
   endfunction

   task automatic send_pair(input logic [23:0] l, input logic [23:0] r);
      int nb = nbits(word_len);
      logic lft = (fmt == 2'd1) ? 1'b0 : 1'b1;
      logic [31:0] pl = slot_pat(l, nb, fmt);
      logic [31:0] pr = slot_pat(r, nb, fmt);
      logic [23:0] el = 24'(l << (24 - nb));
      logic [23:0] er = 24'(r << (24 - nb));
      exp_q.push_back({el, er});
      for (int i = 31; i >= 0; i--) bit_out(lft, pl[i]);
      for (int i = 31; i >= 0; i--) bit_out(~lft, pr[i]);
   endtask

   task automatic run_phase(input logic [1:0] f, input logic [1:0] code, input int npairs,
                            input int gap_at, input string req);
      int nb = nbits(code);
      logic [23:0] mask = 24'((64'd1 << nb) - 1);
      rst_n = 1'b0; run_tick = 1'b0; fmt = f; word_len = code;
      bclk = 1'b0; fsync = 1'b0; sdata = 1'b0;
      exp_q.delete(); prev_l = '0; prev_r = '0; n_rep = 0; audio_req = req;
      repeat (3) @(negedge clk);
      check("R1 line low in reset", 64'(line_out), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 line low before first tick", 64'(line_out), 64'd0);
      run_tick = 1'b1;
      bit_out((f == 2'd1) ? 1'b1 : 1'b0, 1'b0);
      for (int p = 0; p < npairs; p++) begin
         logic [23:0] l, r;
         if (p == gap_at) repeat (3 * 256) @(negedge clk);
         seed = seed * 32'd1103515245 + 32'd12345; l = seed[31:8] & mask;
         seed = seed * 32'd1103515245 + 32'd12345; r = seed[31:8] & mask;
         if (p == 1) begin l = mask; r = 24'd1; end
         send_pair(l, r);
      end
      if (f == 2'd2) bit_out(1'b1, 1'b0);
      repeat (4 * 256) @(negedge clk);
      check("R11 every sample delivered", 64'(exp_q.size()), 64'd0);
      check("R11 repeats occurred", 64'(n_rep >= ((gap_at >= 0) ? 4 : 1)), 64'd1);
   endtask

   initial begin
      run_phase(2'd0, 2'd3, 200, 100, "R7 R10 left-justified 24b");
      run_phase(2'd1, 2'd0, 20, 10, "R8 R10 delayed 16b");
      run_phase(2'd2, 2'd2, 20, -1, "R9 R10 right-justified 20b");
      run_phase(2'd0, 2'd1, 20, -1, "R7 R10 left-justified 18b");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog R11 run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule